// File: doc/BRIEF.md
# Cheat Cartridge Bus Patcher

The patcher sits on the read path between a 16-bit CPU and a cartridge ROM and replaces up to four word locations with values the CPU has programmed. Thirteen word registers are written through a dedicated register window. Four (address, data) patch pairs are decoded from these registers. Each patch address is built from a low word register and six bits of a high word register, so it can reach any word of an 8 MiB byte space.

A three-position switch input selects off, on or trainer. The patch set is captured at the moment the switch enters the on position. While the switch is on, every read whose word address matches a captured patch returns the programmed word in the same cycle. Writing the all-ones value to the mode register hands the low 64 KiB region from the internal boot ROM over to the cartridge. If the switch is on when that write lands, the patch set is captured again. A hard reset restores the power-on state. A soft reset has the same effect, but only while the switch is in trainer.

The switch is handled by a three-state machine: `ST_OFF`, `ST_ON` and `ST_TRAINER`. The named transitions are:

- `ENTER_ON`: from off or trainer into on. This captures the patch set.
- `LEAVE_ON`: from on into off or trainer.
- `OFF_TRAINER`: between off and trainer, in either direction.
- `HOLD`: switch code 3, which keeps the current state.
- `RELATCH`: a self-loop in on, taken when a mode write arrives.

Top module: `cheat_patcher`

## Requirements
- R1: A write with the write enable high goes to register index `reg_wr_addr_i[15:1]`. Indices 0 to 12 are stored. A write to any index above 12 changes nothing, including the low-region mapping.
- R2: Patch k takes its data word from register 0, 4, 7 or 10 (k = 0, 1, 2, 3). Its word address is `{H[13:8], L[15:0]}`, where L is register 1, 5, 8 or 11 and H is register 2, 6, 9 or 12. Bits 15:14 and 7:0 of H are ignored. The byte address is twice the word address.
- R3: Patch addresses and data are captured only on the clock edge where the state enters `ST_ON`. Register writes made while on do not alter the active patches (except as given by R5).
- R4: After any accepted register write that leaves register 3 equal to 0xFFFF, `cart_map_o` is 1. From then on, reads in the low region (word address bits 21:15 all zero) return cartridge data instead of boot data.
- R5: When a write makes register 3 equal to 0xFFFF while the state is `ST_ON`, the patch set is re-captured from the register values that include that write.
- R6: In `ST_OFF` or `ST_TRAINER` no read is substituted, and `patch_hit_o` is 0.
- R7: With HAS_TRAINER = 0, switch code 2 (trainer) is treated as off. A soft reset then has no effect.
- R8: A hard reset (`rst_n` low) clears all registers, the captured patches and `cart_map_o`, and sets the state to `ST_OFF`.
- R9: `soft_rst_i` clears the registers, the captured patches and `cart_map_o` only while the state is `ST_TRAINER`. In any other state it does nothing.
- R10: When two active patches share a word address, the lower-numbered patch supplies the data.
- R11: Reads are combinational, with three cases:
  - A hit returns the patch word with `patch_hit_o` high.
  - Otherwise, a low-region read returns `boot_data_i` while `cart_map_o` is 0.
  - Every other read returns `cart_data_i`.
- R12: Switch encoding is 0 = off, 1 = on, 2 = trainer. Code 3 keeps the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| soft_rst_i | input | 1 | Soft reset request (acts only in trainer) |
| sw_pos_i | input | 2 | Switch position: 0 off, 1 on, 2 trainer, 3 hold |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_wr_addr_i | input | 16 | Low 16 bits of the byte address of the register write |
| reg_wr_data_i | input | 16 | Register write data |
| rd_word_addr_i | input | 22 | Word address of the current read |
| cart_data_i | input | 16 | Word from the cartridge ROM at that address |
| boot_data_i | input | 16 | Word from the internal boot ROM at that address |
| rd_data_o | output | 16 | Word returned to the CPU |
| patch_hit_o | output | 1 | The read was substituted by a patch |
| cart_map_o | output | 1 | The low region is handed to the cartridge |

## Verification
The assertions assume the following about the inputs:
- `soft_rst_i` is low while `rst_n` is asserted.
- The ROM data inputs are settled functions of the read address in the same cycle.

The stimulus changes the switch, the write strobe and the soft reset only just after a falling edge, and holds each for a full cycle. Hard reset is applied only with the switch at off. This keeps each transition of the state machine apart from every other event, except for the deliberate mode write made while on.

// File: rtl/cheat_pkg.sv
package cheat_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ON      = 2'd1,
        ST_TRAINER = 2'd2
    } sw_state_t;

    localparam int NUM_REGS  = 13;
    localparam int NUM_PATCH = 4;
    localparam int IDX_W     = 4;
    localparam int MODE_IDX  = 3;

    // register holding the replacement word of patch p
    function automatic int data_reg(input int p);
        case (p)
            0:       return 0;
            1:       return 4;
            2:       return 7;
            default: return 10;
        endcase
    endfunction

    // register holding the low address word of patch p (high part is the next one)
    function automatic int lo_reg(input int p);
        case (p)
            0:       return 1;
            1:       return 5;
            2:       return 8;
            default: return 11;
        endcase
    endfunction

endpackage

// File: rtl/cheat_regfile.sv
module cheat_regfile
    import cheat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr_i,
    input  logic                               wr_ok_i,
    input  logic [IDX_W-1:0]                   wr_idx_i,
    input  logic [DATA_W-1:0]                  wr_data_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    view_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic hit_w;
        assign hit_w = wr_ok_i && (wr_idx_i == IDX_W'(r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[r] <= '0;
            else if (clr_i)
                regs_q[r] <= '0;
            else if (hit_w)
                regs_q[r] <= wr_data_i;
        end

        // contents as they stand once the current write is applied
        assign view_o[r] = hit_w ? wr_data_i : regs_q[r];
    end

endmodule

// File: rtl/cheat_switch_fsm.sv
module cheat_switch_fsm
    import cheat_pkg::*;
#(
    parameter bit HAS_TRAINER = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sw_pos_i,
    input  logic       relatch_req_i,
    output sw_state_t  state_o,
    output logic       latch_o
);

    sw_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (sw_pos_i)
            2'd0:    state_d = ST_OFF;
            2'd1:    state_d = ST_ON;
            2'd2:    state_d = HAS_TRAINER ? ST_TRAINER : ST_OFF;
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        latch_o = 1'b0;
        unique case (state_q)
            ST_ON:      latch_o = (state_d == ST_ON) && relatch_req_i;
            ST_OFF,
            ST_TRAINER: latch_o = (state_d == ST_ON);
            default:    latch_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/cheat_patch_bank.sv
module cheat_patch_bank
    import cheat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 22
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr_i,
    input  logic                            latch_i,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] view_i,
    input  logic                            active_i,
    input  logic [ADDR_W-1:0]               rd_word_addr_i,
    output logic                            hit_o,
    output logic [DATA_W-1:0]               hit_data_o
);

    localparam int HI_BITS = ADDR_W - DATA_W;
    localparam int HI_LSB  = 8;

    logic [NUM_PATCH-1:0][ADDR_W-1:0] lat_addr_q;
    logic [NUM_PATCH-1:0][DATA_W-1:0] lat_data_q;
    logic [NUM_PATCH-1:0]             match_w;

    for (genvar p = 0; p < NUM_PATCH; p++) begin : g_patch
        localparam int DR = data_reg(p);
        localparam int LR = lo_reg(p);
        localparam int HR = LR + 1;

        logic [ADDR_W-1:0] dec_addr_w;
        assign dec_addr_w = {view_i[HR][HI_LSB+HI_BITS-1:HI_LSB], view_i[LR]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lat_addr_q[p] <= '0;
                lat_data_q[p] <= '0;
            end else if (clr_i) begin
                lat_addr_q[p] <= '0;
                lat_data_q[p] <= '0;
            end else if (latch_i) begin
                lat_addr_q[p] <= dec_addr_w;
                lat_data_q[p] <= view_i[DR];
            end
        end

        assign match_w[p] = active_i && (lat_addr_q[p] == rd_word_addr_i);
    end

    // lowest index has priority: scan from the top down
    always_comb begin
        hit_data_o = '0;
        for (int p = NUM_PATCH - 1; p >= 0; p--) begin
            if (match_w[p])
                hit_data_o = lat_data_q[p];
        end
    end

    assign hit_o = |match_w;

endmodule

// File: rtl/cheat_patcher.sv
module cheat_patcher
    import cheat_pkg::*;
#(
    parameter bit HAS_TRAINER = 1'b1,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 22,
    parameter int LOW_AW      = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic [1:0]        sw_pos_i,
    input  logic              reg_wr_en_i,
    input  logic [15:0]       reg_wr_addr_i,
    input  logic [DATA_W-1:0] reg_wr_data_i,
    input  logic [ADDR_W-1:0] rd_word_addr_i,
    input  logic [DATA_W-1:0] cart_data_i,
    input  logic [DATA_W-1:0] boot_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              patch_hit_o,
    output logic              cart_map_o
);

    localparam logic [14:0] LAST_IDX = 15'(NUM_REGS - 1);

    logic [14:0]                     wr_idx_full;
    logic                            unused_lsb;
    logic                            wr_ok;
    logic                            mode_hit;
    logic                            soft_clr;
    logic                            latch_en;
    logic                            hit_w;
    logic [DATA_W-1:0]               hit_data_w;
    logic                            low_region;
    logic                            cart_map_q;
    sw_state_t                       sw_state;
    logic [NUM_REGS-1:0][DATA_W-1:0] view;

    assign wr_idx_full = reg_wr_addr_i[15:1];
    assign unused_lsb  = reg_wr_addr_i[0];
    assign wr_ok       = reg_wr_en_i && (wr_idx_full <= LAST_IDX);
    assign soft_clr    = soft_rst_i && (sw_state == ST_TRAINER);

    cheat_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (soft_clr),
        .wr_ok_i   (wr_ok),
        .wr_idx_i  (wr_idx_full[IDX_W-1:0]),
        .wr_data_i (reg_wr_data_i),
        .view_o    (view)
    );

    assign mode_hit = wr_ok && (view[MODE_IDX] == {DATA_W{1'b1}});

    cheat_switch_fsm #(.HAS_TRAINER(HAS_TRAINER)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_pos_i      (sw_pos_i),
        .relatch_req_i (mode_hit),
        .state_o       (sw_state),
        .latch_o       (latch_en)
    );

    cheat_patch_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_i          (soft_clr),
        .latch_i        (latch_en),
        .view_i         (view),
        .active_i       (sw_state == ST_ON),
        .rd_word_addr_i (rd_word_addr_i),
        .hit_o          (hit_w),
        .hit_data_o     (hit_data_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cart_map_q <= 1'b0;
        else if (soft_clr)
            cart_map_q <= 1'b0;
        else if (mode_hit)
            cart_map_q <= 1'b1;
    end

    assign low_region = (rd_word_addr_i[ADDR_W-1:LOW_AW] == '0);

    always_comb begin
        if (hit_w)
            rd_data_o = hit_data_w;
        else if (low_region && !cart_map_q)
            rd_data_o = boot_data_i;
        else
            rd_data_o = cart_data_i;
    end

    assign patch_hit_o = hit_w;
    assign cart_map_o  = cart_map_q;

endmodule

// File: rtl/cheat_patcher_chk.sv
module cheat_patcher_chk #(
    parameter bit HAS_TRAINER = 1'b1,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 22,
    parameter int LOW_AW      = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst_i,
    input logic              reg_wr_en_i,
    input logic [1:0]        state,
    input logic              latch_en,
    input logic              patch_hit_o,
    input logic              cart_map_o,
    input logic [ADDR_W-1:0] rd_word_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [DATA_W-1:0] boot_data_i
);

    a_r6_no_hit_unless_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd1) |-> !patch_hit_o);

    a_r4_map_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cart_map_o) |-> $past(reg_wr_en_i));

    a_r9_soft_clears_map: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst_i && (state == 2'd2)) |-> !cart_map_o);

    a_r3_capture_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == 2'd1) && ($past(state) != 2'd1)) |-> $past(latch_en));

    a_r7_no_trainer_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_TRAINER) |-> (state != 2'd2));

    a_r11_boot_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (!patch_hit_o && !cart_map_o && (rd_word_addr_i[ADDR_W-1:LOW_AW] == '0))
            |-> (rd_data_o == boot_data_i));

endmodule

bind cheat_patcher cheat_patcher_chk #(
    .HAS_TRAINER (HAS_TRAINER),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .LOW_AW      (LOW_AW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .soft_rst_i     (soft_rst_i),
    .reg_wr_en_i    (reg_wr_en_i),
    .state          (sw_state),
    .latch_en       (latch_en),
    .patch_hit_o    (patch_hit_o),
    .cart_map_o     (cart_map_o),
    .rd_word_addr_i (rd_word_addr_i),
    .rd_data_o      (rd_data_o),
    .boot_data_i    (boot_data_i)
);

// File: tb/test_cheat_patcher.sv
`timescale 1ns/1ps
module test_cheat_patcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [1:0]  sw_pos = 2'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [21:0] rd_addr = '0;
    logic [15:0] cart_data, boot_data;
    logic [15:0] rd_data, b_rd_data;
    logic        hit, b_hit, cmap, b_cmap;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] cart_fn(input logic [21:0] a);
        return {a[21:16], a[9:0]} ^ 16'h5A3C;
    endfunction
    function automatic logic [15:0] boot_fn(input logic [21:0] a);
        return ~a[15:0] ^ 16'h0F0F;
    endfunction

    assign cart_data = cart_fn(rd_addr);
    assign boot_data = boot_fn(rd_addr);

    cheat_patcher i_cheat_patcher (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .sw_pos_i(sw_pos),
        .reg_wr_en_i(wr_en), .reg_wr_addr_i(wr_addr), .reg_wr_data_i(wr_data),
        .rd_word_addr_i(rd_addr), .cart_data_i(cart_data), .boot_data_i(boot_data),
        .rd_data_o(rd_data), .patch_hit_o(hit), .cart_map_o(cmap)
    );

    cheat_patcher #(.HAS_TRAINER(1'b0)) i_cheat_patcher_basic (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .sw_pos_i(sw_pos),
        .reg_wr_en_i(wr_en), .reg_wr_addr_i(wr_addr), .reg_wr_data_i(wr_data),
        .rd_word_addr_i(rd_addr), .cart_data_i(cart_data), .boot_data_i(boot_data),
        .rd_data_o(b_rd_data), .patch_hit_o(b_hit), .cart_map_o(b_cmap)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference model of the main instance
    logic [15:0] m_regs [13];
    logic [21:0] m_addr [4];
    logic [15:0] m_data [4];
    int          m_state = 0;
    bit          m_map = 0;

    function automatic void m_clear();
        for (int i = 0; i < 13; i++) m_regs[i] = '0;
        for (int p = 0; p < 4; p++) begin m_addr[p] = '0; m_data[p] = '0; end
        m_map = 0;
    endfunction

    function automatic void m_capture();
        int dr[4] = '{0, 4, 7, 10};
        int lr[4] = '{1, 5, 8, 11};
        for (int p = 0; p < 4; p++) begin
            m_data[p] = m_regs[dr[p]];
            m_addr[p] = {m_regs[lr[p]+1][13:8], m_regs[lr[p]]};
        end
    endfunction

    typedef struct {
        logic [21:0] addr;
        logic [15:0] data;
        logic        hit;
        string       req;
    } item_t;
    item_t sb_q[$];

    // monitor: pops each expected item one ns after the driver applied it
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                chk({it.req, " data"}, {16'h0, rd_data}, {16'h0, it.data});
                chk({it.req, " hit"}, {31'h0, hit}, {31'h0, it.hit});
            end
        end
    end

    task automatic rd(input logic [21:0] a, input string req);
        item_t it;
        @(negedge clk);
        rd_addr = a;
        it.addr = a; it.req = req; it.hit = 1'b0;
        if (a[21:15] == '0 && !m_map) it.data = boot_fn(a);
        else it.data = cart_fn(a);
        if (m_state == 1) begin
            for (int p = 3; p >= 0; p--) begin
                if (m_addr[p] == a) begin it.data = m_data[p]; it.hit = 1'b1; end
            end
        end
        sb_q.push_back(it);
    endtask

    task automatic wr_reg(input int idx, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'(idx * 2); wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (idx <= 12) begin
            m_regs[idx] = d;
            if (m_regs[3] == 16'hFFFF) begin
                m_map = 1;
                if (m_state == 1) m_capture();
            end
        end
    endtask

    task automatic set_sw(input logic [1:0] p);
        @(negedge clk);
        sw_pos = p;
        @(posedge clk);
        #1;
        if (p == 2'd1 && m_state != 1) m_capture();
        if (p != 2'd3) m_state = p;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(posedge clk);
        #1 soft_rst = 1'b0;
        if (m_state == 2) m_clear();
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_clear();
        m_state = 0;
    endtask

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: state after reset
        rd(22'h000000, "R8 boot at 0 after reset");
        rd(22'h020000, "R11 cart above low region");
        @(negedge clk); #1;
        chk("R8 map cleared", {31'h0, cmap}, 32'h0);

        // program patches (R2): p0 and p2 share an address (R10)
        wr_reg(0, 16'h1111); wr_reg(1, 16'h0100); wr_reg(2, 16'h0000);
        wr_reg(4, 16'h2222); wr_reg(5, 16'h4321); wr_reg(6, 16'hFF00);
        wr_reg(7, 16'h3333); wr_reg(8, 16'h0100); wr_reg(9, 16'h0000);
        wr_reg(10, 16'h4444); wr_reg(11, 16'hBEEF); wr_reg(12, 16'h0580);

        rd(22'h3F4321, "R6 no patch while off");
        set_sw(2'd1);
        rd(22'h3F4321, "R2 masked high part");
        rd(22'h000100, "R10 lowest index wins");
        rd(22'h05BEEF, "R2 patch 3");
        rd(22'h05BEF0, "R11 neighbour unpatched");
        rd(22'h000050, "R11 low region boot");

        // R3: writes while on leave the active set alone
        wr_reg(0, 16'h9999);
        rd(22'h000100, "R3 no capture while on");

        // R1: out-of-range index ignored, R4: mode value
        wr_reg(3, 16'h1234);
        wr_reg(13, 16'hFFFF);
        @(negedge clk); #1;
        chk("R1 index 13 ignored", {31'h0, cmap}, 32'h0);
        rd(22'h000050, "R1 still boot");
        wr_reg(3, 16'hFFFF);
        @(negedge clk); #1;
        chk("R4 map set", {31'h0, cmap}, 32'h1);
        rd(22'h000100, "R5 recaptured");
        rd(22'h000050, "R4 low region cart");

        set_sw(2'd3);
        rd(22'h000100, "R12 hold keeps on");

        // R6 trainer, R7 basic variant
        set_sw(2'd2);
        rd(22'h3F4321, "R6 no patch in trainer");
        #1 chk("R7 basic no hit", {31'h0, b_hit}, 32'h0);

        pulse_soft();
        @(negedge clk); #1;
        chk("R9 soft clears map", {31'h0, cmap}, 32'h0);
        chk("R7 basic ignores soft", {31'h0, b_cmap}, 32'h1);

        set_sw(2'd1);
        rd(22'h000000, "R9 cleared regs patch at 0");
        rd(22'h000100, "R9 old patch gone");
        #1 chk("R7 basic keeps regs", {16'h0, b_rd_data}, 32'h9999);

        wr_reg(3, 16'hFFFF);
        pulse_soft();
        @(negedge clk); #1;
        chk("R9 soft ignored when on", {31'h0, cmap}, 32'h1);
        rd(22'h000000, "R9 patch kept when on");

        set_sw(2'd0);
        hard_reset();
        @(negedge clk); #1;
        chk("R8 hard reset map", {31'h0, cmap}, 32'h0);
        rd(22'h000000, "R8 boot after hard reset");
        set_sw(2'd1);
        rd(22'h000000, "R8 regs cleared by hard reset");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule